// File: doc/BRIEF.md
# USB PHY Power Sequencer

This block powers four USB PHY ports up and down on request: a device port, a host port and two inter-chip ports. A request names a port and asks it to be turned on or released. Ports depend on one another. The host port needs the device port running. Each inter-chip port needs both the device port and the host port. The sequencer therefore expands one request into an ordered list of internal power steps.

Every port keeps two reference counts. The external count tracks requests made for that port itself. The internal count tracks every user, including the ports that depend on it. The block touches the hardware controls only when a count moves between zero and one. Other requests only adjust the count.

The block drives a power-down word, a reset word, three isolation-release bits, a reference-clock word and a device/host mode select. A port power-up runs a fixed sequence: clock setup, isolation release, power bits cleared, a timed reset pulse, and a timed settle. Delays are counted in clock cycles derived from a cycles-per-microsecond parameter. Requests are handled one at a time and are acknowledged with a one-cycle done pulse.

Top module: `usb_phy_pwr_seq`

## Requirements
- R1: After reset the outputs are: pwrWord = 0x7FF9 (every port off), rstWord = 0, clkWord = 0, isoRel = 0, modeSel = 1, busy = 0, done = 0.
- R2: A port is on when its pwrWord bits are all clear, and off when they are all set. The device port uses bits 0, 3, 4 and 5. The host port uses bits 6, 7 and 8. Inter-chip port 0 uses bits 9, 10 and 11. Inter-chip port 1 uses bits 12, 13 and 14. reqPort selects the port: 0 is device, 1 is host, 2 is inter-chip 0 and 3 is inter-chip 1.
- R3: A port power-up raises that port's reset bits in rstWord for exactly 10*CYC_PER_US cycles. The device port uses bit 0. The host port uses bits 3, 4 and 10. Inter-chip port 0 uses bits 6 and 9. Inter-chip port 1 uses bits 5 and 9. rstWord is nonzero only while the block is busy.
- R4: When a request ends with a port power-up, done rises exactly 80*CYC_PER_US cycles after the reset bits clear.
- R5: A port power-up runs in a fixed order: it first writes clkWord to 0x80 | refCode (bit 7 set, bits 2:0 holding the code), then sets the isolation bit, then clears the power bits, then pulses reset.
- R6: A port power-down first drops its isolation bit and then sets its power bits. No reset pulse is issued.
- R7: isoRel bit 0 is shared by the device and host ports. Bit 1 belongs to inter-chip port 0 and bit 2 to inter-chip port 1. Each bit is 1 while its port is powered.
- R8: An on request for the host port powers the device port and then the host port. An on request for an inter-chip port powers the device port, then the host port, then the requested port.
- R9: A release of the host port powers down the host and then the device port. A release of an inter-chip port powers down that port, then the host port, then the device port. In every case a port is affected only if its internal count reaches zero.
- R10: The mode select changes only on the first on request or the last release of a port. A device on request drives modeSel = 0. A host on request drives modeSel = 1. The last release of the device port drives modeSel = 1.
- R11: Hardware actions happen only when a count moves from 0 to 1 or from 1 to 0. A repeated on request, or a release that leaves the count above zero, only adjusts the count.
- R12: A request (reqValid = 1, reqOn = 1 for on, 0 for release) is accepted only while busy = 0. busy stays high until done pulses for one cycle. A request raised while busy is ignored.
- R13: A release when the external count is zero, or an on request when the external count is already 2^CNT_W-1, is ignored. reqErr is 1 in that request's done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request strobe |
| reqPort | input | 2 | Target port: 0 device, 1 host, 2 inter-chip 0, 3 inter-chip 1 |
| reqOn | input | 1 | 1 = power on, 0 = release |
| refCode | input | 3 | Reference frequency code written at clock setup |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |
| reqErr | output | 1 | The completed request was rejected (valid with done) |
| pwrWord | output | 16 | Power-down control word |
| rstWord | output | 16 | Reset control word |
| clkWord | output | 8 | Reference clock control word |
| isoRel | output | 3 | Isolation-release bits |
| modeSel | output | 1 | 0 = device mode, 1 = host mode |

## Verification
The bench builds the block with CYC_PER_US = 2, so the reset pulse lasts 20 cycles and the settle lasts 160. Every timed window can therefore be measured to the cycle within a few thousand cycles of run time. CNT_W = 2 caps the external count at 3, so the saturation rejection is reached after three repeated on requests. Random request mixes are compared with a reference model of the counts, the expected order of power events and the final control words.

// File: rtl/usbpwr_pkg.sv
package usbpwr_pkg;

  typedef enum logic [1:0] {
    PORT_DEV  = 2'd0,
    PORT_HOST = 2'd1,
    PORT_IC0  = 2'd2,
    PORT_IC1  = 2'd3
  } portT;

  typedef struct packed {
    logic clkSetup;
    logic isoOn;
    logic isoOff;
    logic pwrUp;
    logic pwrDown;
    logic rstSet;
    logic rstClr;
    logic modeLoad;
    logic modeVal;
    logic timerLoad;
    logic timerLong;
    portT port;
  } strobeT;

  localparam logic [15:0] PWR_ALL = 16'h7FF9;

  function automatic logic [15:0] pwrMask(portT p);
    case (p)
      PORT_DEV:  return 16'h0039;
      PORT_HOST: return 16'h01C0;
      PORT_IC0:  return 16'h0E00;
      default:   return 16'h7000;
    endcase
  endfunction

  function automatic logic [15:0] rstMask(portT p);
    case (p)
      PORT_DEV:  return 16'h0001;
      PORT_HOST: return 16'h0418;
      PORT_IC0:  return 16'h0240;
      default:   return 16'h0220;
    endcase
  endfunction

  function automatic logic [1:0] isoIdx(portT p);
    case (p)
      PORT_IC0: return 2'd1;
      PORT_IC1: return 2'd2;
      default:  return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/usbpwr_ctrl.sv
module usbpwr_ctrl
  import usbpwr_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqPort,
  input  logic       reqOn,
  input  logic       timerDone,
  output strobeT     stb,
  output logic       busy,
  output logic       done,
  output logic       reqErr
);
  localparam int INT_W = CNT_W + 2;
  localparam logic [CNT_W-1:0] EXT_MAX = {CNT_W{1'b1}};

  typedef enum logic [3:0] {
    S_IDLE, S_MODE, S_NEXT, S_CLK, S_ISO, S_PWR, S_RST, S_RSTW,
    S_REL, S_SETTLE, S_ISOOFF, S_PWROFF, S_DONE
  } stateT;

  stateT state;
  logic [CNT_W-1:0] extCnt [4];
  logic [INT_W-1:0] intCnt [4];
  portT opPort [4];
  logic [1:0] opCnt, opIdx;
  logic opOn, errReg, modeReg;
  portT curPort;

  portT reqP;
  logic [CNT_W-1:0] reqExt;
  logic goHw, reqBad, modeNeed, modeV;
  portT lstPort [3];
  logic [1:0] lstCnt;
  portT nxtPort;
  logic [INT_W-1:0] nxtOld;

  always_comb begin
    reqP   = portT'(reqPort);
    reqExt = extCnt[reqPort];
    reqBad = reqOn ? (reqExt == EXT_MAX) : (reqExt == '0);
    goHw   = !reqBad && (reqOn ? (reqExt == '0) : (reqExt == CNT_W'(1)));
    modeNeed = goHw && ((reqP == PORT_DEV) || (reqP == PORT_HOST && reqOn));
    modeV    = !(reqP == PORT_DEV && reqOn);
    lstPort[0] = PORT_DEV;
    lstPort[1] = PORT_DEV;
    lstPort[2] = PORT_DEV;
    case (reqP)
      PORT_DEV: lstCnt = 2'd1;
      PORT_HOST: begin
        lstCnt = 2'd2;
        lstPort[0] = reqOn ? PORT_DEV : PORT_HOST;
        lstPort[1] = reqOn ? PORT_HOST : PORT_DEV;
      end
      default: begin
        lstCnt = 2'd3;
        lstPort[0] = reqOn ? PORT_DEV : reqP;
        lstPort[1] = PORT_HOST;
        lstPort[2] = reqOn ? reqP : PORT_DEV;
      end
    endcase
    nxtPort = opPort[opIdx];
    nxtOld  = intCnt[nxtPort];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      opCnt   <= '0;
      opIdx   <= '0;
      opOn    <= 1'b0;
      errReg  <= 1'b0;
      modeReg <= 1'b1;
      curPort <= PORT_DEV;
      for (int i = 0; i < 4; i++) begin
        extCnt[i] <= '0;
        intCnt[i] <= '0;
        opPort[i] <= PORT_DEV;
      end
    end else begin
      case (state)
        S_IDLE: if (reqValid) begin
          errReg  <= reqBad;
          opOn    <= reqOn;
          opIdx   <= '0;
          opCnt   <= goHw ? lstCnt : 2'd0;
          modeReg <= modeV;
          for (int i = 0; i < 3; i++) opPort[i] <= lstPort[i];
          if (!reqBad) extCnt[reqPort] <= reqOn ? reqExt + 1'b1 : reqExt - 1'b1;
          state <= modeNeed ? S_MODE : S_NEXT;
        end
        S_MODE: state <= S_NEXT;
        S_NEXT: begin
          if (opIdx == opCnt) state <= S_DONE;
          else begin
            curPort <= nxtPort;
            opIdx   <= opIdx + 1'b1;
            if (opOn) begin
              intCnt[nxtPort] <= nxtOld + 1'b1;
              if (nxtOld == '0) state <= S_CLK;
            end else begin
              intCnt[nxtPort] <= nxtOld - 1'b1;
              if (nxtOld == INT_W'(1)) state <= S_ISOOFF;
            end
          end
        end
        S_CLK:    state <= S_ISO;
        S_ISO:    state <= S_PWR;
        S_PWR:    state <= S_RST;
        S_RST:    state <= S_RSTW;
        S_RSTW:   if (timerDone) state <= S_REL;
        S_REL:    state <= S_SETTLE;
        S_SETTLE: if (timerDone) state <= S_NEXT;
        S_ISOOFF: state <= S_PWROFF;
        S_PWROFF: state <= S_NEXT;
        default:  state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    stb = '0;
    stb.port      = curPort;
    stb.modeVal   = modeReg;
    stb.modeLoad  = (state == S_MODE);
    stb.clkSetup  = (state == S_CLK);
    stb.isoOn     = (state == S_ISO);
    stb.pwrUp     = (state == S_PWR);
    stb.rstSet    = (state == S_RST);
    stb.rstClr    = (state == S_REL);
    stb.timerLoad = (state == S_RST) || (state == S_REL);
    stb.timerLong = (state == S_REL);
    stb.isoOff    = (state == S_ISOOFF);
    stb.pwrDown   = (state == S_PWROFF);
  end

  assign busy   = (state != S_IDLE);
  assign done   = (state == S_DONE);
  assign reqErr = done && errReg;

endmodule

// File: rtl/usbpwr_dp.sv
module usbpwr_dp
  import usbpwr_pkg::*;
#(
  parameter int CYC_PER_US = 100
) (
  input  logic        clk,
  input  logic        rstN,
  input  strobeT      stb,
  input  logic [2:0]  refCode,
  output logic        timerDone,
  output logic [15:0] pwrWord,
  output logic [15:0] rstWord,
  output logic [7:0]  clkWord,
  output logic [2:0]  isoRel,
  output logic        modeSel
);
  localparam int RST_CYC = 10 * CYC_PER_US;
  localparam int SET_CYC = 80 * CYC_PER_US;
  localparam int TW = $clog2(SET_CYC + 1);
  localparam logic [TW-1:0] RST_LOAD = TW'(RST_CYC - 2);
  localparam logic [TW-1:0] SET_LOAD = TW'(SET_CYC - 2);

  logic [TW-1:0] timer;
  logic [1:0] isoSel;

  assign isoSel = isoIdx(stb.port);
  assign timerDone = (timer == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pwrWord <= PWR_ALL;
      rstWord <= '0;
      clkWord <= '0;
      modeSel <= 1'b1;
      timer   <= '0;
    end else begin
      if (stb.pwrUp)    pwrWord <= pwrWord & ~pwrMask(stb.port);
      if (stb.pwrDown)  pwrWord <= pwrWord | pwrMask(stb.port);
      if (stb.rstSet)   rstWord <= rstWord | rstMask(stb.port);
      if (stb.rstClr)   rstWord <= rstWord & ~rstMask(stb.port);
      if (stb.clkSetup) clkWord <= {1'b1, clkWord[6:3], refCode};
      if (stb.modeLoad) modeSel <= stb.modeVal;
      if (stb.timerLoad) timer <= stb.timerLong ? SET_LOAD : RST_LOAD;
      else if (timer != '0) timer <= timer - 1'b1;
    end
  end

  for (genvar g = 0; g < 3; g++) begin : g_iso
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) isoRel[g] <= 1'b0;
      else if (isoSel == 2'(g)) begin
        if (stb.isoOn)       isoRel[g] <= 1'b1;
        else if (stb.isoOff) isoRel[g] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/usb_phy_pwr_seq.sv
module usb_phy_pwr_seq
  import usbpwr_pkg::*;
#(
  parameter int CYC_PER_US = 100,
  parameter int CNT_W      = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic [1:0]  reqPort,
  input  logic        reqOn,
  input  logic [2:0]  refCode,
  output logic        busy,
  output logic        done,
  output logic        reqErr,
  output logic [15:0] pwrWord,
  output logic [15:0] rstWord,
  output logic [7:0]  clkWord,
  output logic [2:0]  isoRel,
  output logic        modeSel
);
  strobeT stb;
  logic timerDone;

  usbpwr_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqPort(reqPort),
    .reqOn(reqOn), .timerDone(timerDone), .stb(stb), .busy(busy),
    .done(done), .reqErr(reqErr)
  );

  usbpwr_dp #(.CYC_PER_US(CYC_PER_US)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .refCode(refCode),
    .timerDone(timerDone), .pwrWord(pwrWord), .rstWord(rstWord),
    .clkWord(clkWord), .isoRel(isoRel), .modeSel(modeSel)
  );

endmodule

// File: rtl/usbpwr_chk.sv
module usbpwr_chk (
  input logic       clk,
  input logic       rstN,
  input logic       busy,
  input logic       done,
  input logic       rstAny,
  input logic       rstDev,
  input logic [3:0] pwrLow,
  input logic [2:0] isoRel,
  input logic       modeSel
);
  // R3
  rst_only_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstAny |-> busy);
  // R3
  rst_port_on_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstDev |-> !pwrLow[0]);
  // R5
  iso_before_up_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(pwrLow[0]) && !pwrLow[0]) |-> $past(isoRel[0]));
  // R5
  iso_before_up_ic0_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(pwrLow[2]) && !pwrLow[2]) |-> $past(isoRel[1]));
  // R6
  iso_before_down_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(pwrLow[1]) && pwrLow[1]) |-> !$past(isoRel[0]));
  // R6
  iso_before_down_ic1_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(pwrLow[3]) && pwrLow[3]) |-> !$past(isoRel[2]));
  // R12
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R12
  done_in_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);
  // R10
  mode_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !$past(busy)) |-> $stable(modeSel));
endmodule

bind usb_phy_pwr_seq usbpwr_chk u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .done(done),
  .rstAny(|rstWord), .rstDev(rstWord[0]),
  .pwrLow({pwrWord[12], pwrWord[9], pwrWord[6], pwrWord[0]}),
  .isoRel(isoRel), .modeSel(modeSel)
);

// File: tb/tb_usb_phy_pwr_seq.sv
`timescale 1ns/1ps
module tb_usb_phy_pwr_seq;
  localparam int CPU = 2;
  localparam int CW = 2;
  localparam int RSTW = 10 * CPU;
  localparam int SETW = 80 * CPU;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 1'b0, reqOn = 1'b0;
  logic [1:0] reqPort = '0;
  logic [2:0] refCode = 3'd5;
  logic busy, done, reqErr, modeSel;
  logic [15:0] pwrWord, rstWord;
  logic [7:0] clkWord;
  logic [2:0] isoRel;

  usb_phy_pwr_seq #(.CYC_PER_US(CPU), .CNT_W(CW)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqPort(reqPort),
    .reqOn(reqOn), .refCode(refCode), .busy(busy), .done(done),
    .reqErr(reqErr), .pwrWord(pwrWord), .rstWord(rstWord),
    .clkWord(clkWord), .isoRel(isoRel), .modeSel(modeSel)
  );

  always #2 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] mPwr(int p);
    case (p) 0: return 16'h0039; 1: return 16'h01C0; 2: return 16'h0E00; default: return 16'h7000; endcase
  endfunction
  function automatic logic [15:0] mRst(int p);
    case (p) 0: return 16'h0001; 1: return 16'h0418; 2: return 16'h0240; default: return 16'h0220; endcase
  endfunction
  function automatic int mIso(int p);
    return (p < 2) ? 0 : p - 1;
  endfunction

  // monitor of power events and reset pulse timing
  int evPort [8]; bit evOn [8]; int evN = 0;
  logic [15:0] prevPwr = 16'h7FF9;
  int rstLen = 0, rstFallCyc = -1;
  always @(negedge clk) if (rstN) begin
    for (int p = 0; p < 4; p++) begin
      if ((prevPwr & mPwr(p)) == mPwr(p) && (pwrWord & mPwr(p)) == 0) begin
        if (evN < 8) begin evPort[evN] = p; evOn[evN] = 1; end
        evN++;
      end
      if ((prevPwr & mPwr(p)) == 0 && (pwrWord & mPwr(p)) == mPwr(p)) begin
        if (evN < 8) begin evPort[evN] = p; evOn[evN] = 0; end
        evN++;
      end
    end
    prevPwr = pwrWord;
    if (rstWord != 0) begin
      if (rstLen == 0)
        chk(rstWord == 16'h0001 || rstWord == 16'h0418 || rstWord == 16'h0240 ||
            rstWord == 16'h0220, "R3 reset bit pattern", rstWord, 0);
      rstLen++;
    end else if (rstLen != 0) begin
      chk(rstLen == RSTW, "R3 reset pulse width", rstLen, RSTW);
      rstLen = 0;
      rstFallCyc = cyc;
    end
  end

  // reference model
  int ext [4]; int intc [4];
  logic [15:0] ePwr = 16'h7FF9; logic [2:0] eIso = 0; logic eMode = 1; logic [7:0] eClk = 0;
  int xPort [8]; bit xOn [8]; int xN;

  task automatic mInt(int p, bit on);
    if (on) begin
      if (intc[p] == 0) begin
        ePwr &= ~mPwr(p); eIso[mIso(p)] = 1; eClk = {5'b10000, refCode};
        xPort[xN] = p; xOn[xN] = 1; xN++;
      end
      intc[p]++;
    end else begin
      if (intc[p] == 1) begin
        ePwr |= mPwr(p); eIso[mIso(p)] = 0;
        xPort[xN] = p; xOn[xN] = 0; xN++;
      end
      intc[p]--;
    end
  endtask

  task automatic doReq(int p, bit on, bit inject);
    bit eErr, hw;
    int doneCyc, guard;
    xN = 0; eErr = 0; hw = 0;
    if (on) begin
      if (ext[p] == 3) eErr = 1; else begin hw = (ext[p] == 0); ext[p]++; end
    end else begin
      if (ext[p] == 0) eErr = 1; else begin hw = (ext[p] == 1); ext[p]--; end
    end
    if (hw) begin
      if (on) begin
        if (p == 0) eMode = 0;
        if (p == 1) eMode = 1;
        if (p >= 1) mInt(0, 1);
        if (p >= 2) mInt(1, 1);
        mInt(p, 1);
      end else begin
        if (p == 0) eMode = 1;
        mInt(p, 0);
        if (p >= 2) mInt(1, 0);
        if (p >= 1) mInt(0, 0);
      end
    end
    @(negedge clk);
    evN = 0;
    reqValid = 1; reqPort = 2'(p); reqOn = on;
    @(negedge clk);
    reqValid = 0;
    if (inject) begin
      repeat (4) @(negedge clk);
      chk(busy == 1, "R12 busy during request", busy, 1);
      reqValid = 1; reqPort = 2'd2; reqOn = 1;
      @(negedge clk);
      reqValid = 0;
    end
    guard = 0;
    while (!done && guard < 5000) begin @(negedge clk); guard++; end
    doneCyc = cyc;
    chk(done == 1, "R12 done reached", done, 1);
    chk(reqErr == eErr, "R13 error flag", reqErr, eErr);
    chk(evN == xN, "R8 R9 R11 event count", evN, xN);
    for (int i = 0; i < xN && i < evN; i++)
      chk(evPort[i] == xPort[i] && evOn[i] == xOn[i], "R8 R9 event order",
          evPort[i] * 2 + evOn[i], xPort[i] * 2 + xOn[i]);
    if (xN > 0 && xOn[xN-1])
      chk(doneCyc - rstFallCyc == SETW, "R4 settle time", doneCyc - rstFallCyc, SETW);
    chk(pwrWord == ePwr, "R2 power word", pwrWord, ePwr);
    chk(isoRel == eIso, "R7 isolation bits", isoRel, eIso);
    chk(modeSel == eMode, "R10 mode select", modeSel, eMode);
    chk(clkWord == eClk, "R5 clock word", clkWord, eClk);
    chk(rstWord == 0, "R6 reset idle", rstWord, 0);
    @(negedge clk);
    chk(busy == 0 && done == 0, "R12 return to idle", {busy, done}, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL R12 watchdog actual=expired expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int seed;
    for (int i = 0; i < 4; i++) begin ext[i] = 0; intc[i] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk(pwrWord == 16'h7FF9, "R1 power word", pwrWord, 16'h7FF9);
    chk(rstWord == 0 && clkWord == 0 && isoRel == 0, "R1 words clear",
        {rstWord, clkWord, 5'b0, isoRel}, 0);
    chk(modeSel == 1 && busy == 0 && done == 0, "R1 mode and handshake",
        {modeSel, busy, done}, 3'b100);
    // directed sequences
    doReq(0, 1, 0);            // R5 R10 device from cold
    doReq(1, 1, 1);            // R8 host, R12 injected request ignored
    doReq(0, 0, 0);            // R10 R11 device release, still held by host
    doReq(0, 0, 0);            // R13 release below zero
    doReq(1, 0, 0);            // R9 host then device down
    doReq(3, 1, 0);            // R8 inter-chip 1 chain
    refCode = 3'd2;
    doReq(2, 1, 0);            // R7 R11 inter-chip 0 only
    doReq(3, 0, 0);            // R6 inter-chip 1 alone
    doReq(2, 0, 0);            // R9 full chain down
    doReq(0, 1, 0);            // R5 clock reprogrammed with new code
    doReq(0, 1, 0);            // R11 count only
    doReq(0, 1, 0);
    doReq(0, 1, 0);            // R13 saturated
    for (int i = 0; i < 3; i++) doReq(0, 0, 0);
    // constrained random mix
    seed = $urandom(32'h5EED);
    for (int i = 0; i < 70; i++) begin
      int p; bit on;
      p = $urandom_range(3, 0);
      on = ($urandom_range(99, 0) < 55);
      refCode = 3'($urandom_range(7, 0));
      doReq(p, on, 0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule